// File: doc/BRIEF.md
# Serial Line Receiver with Break Handling

This block turns an asynchronous serial bit stream into characters. A tick input marks each of sixteen oversampling slots per bit period. The receiver waits for the line to drop from the mark level, confirms the start bit at its midpoint, and then takes one sample in the middle of each data bit. It also samples an optional parity bit and the single stop bit. Every finished character appears on a parallel output for one clock cycle, along with three tags: parity error, framing error and break.

Two error paths need special handling. If the stop bit is sampled low, the character is reported with a framing error. The receiver then treats that low sample as the midpoint of the next start bit, so it carries straight on with data bits and does not wait for a new falling edge. If the line stays at the space level for a whole character frame, the receiver reports one break character and then ignores the line until it goes high again. Word length, parity enable and parity sense are configuration inputs. The line input is passed through a two-stage synchronizer before the receiver uses it.

Top module: `uart_rx_brk`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `rx_valid`, `rx_data`, `rx_perr`, `rx_ferr` and `rx_brk` are all zero.
- R2: Data bits arrive least significant bit first. `word_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The received bits are right-aligned in `rx_data`, and all bits above the word length read zero.
- R3: With `par_en`=1, one parity bit follows the data bits. With `par_odd`=0 (even parity) it must equal the XOR of the data bits; with `par_odd`=1 it must equal the inverse of that XOR. If it does not, `rx_perr` is set. With `par_en`=0 no parity bit is expected and `rx_perr` stays 0.
- R4: A stop bit sampled as 0 sets `rx_ferr` for that character. The data bits are still delivered.
- R5: After a framing error that is not a break, the low stop sample serves as the start bit of the next character. Data bits sent directly after the bad stop bit, with no further start bit, are received correctly.
- R6: If the line is 0 for the start bit, every data bit, the parity bit (when enabled) and the stop bit, exactly one character is produced. It has `rx_data`=0, `rx_brk`=1, `rx_ferr`=1 and `rx_perr`=0.
- R7: After a break, no further character is produced while the line stays low, however long that is. Once the line returns to 1, the next start bit is received normally.
- R8: A low pulse that has ended by the midpoint of the start bit (the 8th tick) is ignored, and no character is produced.
- R9: `rx_valid` is high for exactly one cycle per character. It rises during the stop bit period, about half a bit after the stop bit begins on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial line; 1 = mark/idle |
| os_tick | input | 1 | Oversampling tick, 16 per bit period |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_valid | output | 1 | One-cycle strobe for a completed character |
| rx_data | output | 8 | Received character, right-aligned |
| rx_perr | output | 1 | Parity mismatch tag |
| rx_ferr | output | 1 | Stop bit low tag |
| rx_brk | output | 1 | Break tag |

## Verification
Each character result appears in the cycle after the tick that samples the midpoint of the stop bit. Counted from the start of the stop bit on the line, that is the two synchronizer stages, eight oversampling ticks and one output register. The bench records the cycle in which the stop bit begins and the cycle in which each strobe arrives. A strobe must fall inside that stop bit window, and the strobe count must rise by exactly the expected number once a frame has finished. For the glitch and break cases, the absence of a character is checked by the strobe count staying unchanged across the whole window in which the line is held.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

    localparam int DATA_MAX = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
    } rx_cfg_t;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic                perr;
        logic                ferr;
        logic                brk;
    } rx_char_t;

    function automatic logic [3:0] word_bits(input logic [1:0] w);
        return 4'd5 + {2'b00, w};
    endfunction

    function automatic logic [DATA_MAX-1:0] word_mask(input logic [1:0] w);
        return {DATA_MAX{1'b1}} >> (4'd3 - {2'b00, w});
    endfunction

    function automatic logic want_parity(input logic [DATA_MAX-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/uart_rxb_sync.sv
module uart_rxb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rxb_core.sv
module uart_rxb_core
    import uart_rxb_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rx,
    input  logic     tick,
    input  rx_cfg_t  cfg,
    output logic     valid,
    output rx_char_t ch
);
    localparam int CNT_W = $clog2(OVS);
    localparam int MID   = OVS / 2;
    localparam int IDX_W = $clog2(DATA_MAX);

    rx_state_e           st;
    logic [CNT_W-1:0]    cnt;
    logic [IDX_W-1:0]    idx;
    logic [DATA_MAX-1:0] shreg;
    logic                seen_one;
    logic                pbit;

    logic                at_mid, at_end, last_bit;
    logic [3:0]          nbits;
    logic [DATA_MAX-1:0] aligned;
    logic                stop_bad, is_brk, par_bad;

    always_comb begin
        nbits    = word_bits(cfg.wlen);
        at_mid   = (cnt == CNT_W'(MID - 1));
        at_end   = (cnt == CNT_W'(OVS - 1));
        last_bit = ({{(4-IDX_W){1'b0}}, idx} == nbits - 4'd1);
        aligned  = shreg >> (4'(DATA_MAX) - nbits);
        stop_bad = !rx;
        is_brk   = stop_bad && !seen_one;
        par_bad  = cfg.par_en && (pbit != want_parity(aligned, cfg.par_odd));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            seen_one <= 1'b0;
            pbit     <= 1'b0;
            valid    <= 1'b0;
            ch       <= '0;
        end else begin
            valid <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: begin
                        if (!rx) begin
                            st  <= ST_START;
                            cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (at_mid) begin
                            cnt      <= '0;
                            idx      <= '0;
                            shreg    <= '0;
                            seen_one <= 1'b0;
                            st       <= rx ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_end) begin
                            cnt      <= '0;
                            shreg    <= {rx, shreg[DATA_MAX-1:1]};
                            seen_one <= seen_one | rx;
                            if (last_bit) st <= cfg.par_en ? ST_PAR : ST_STOP;
                            else          idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (at_end) begin
                            cnt      <= '0;
                            pbit     <= rx;
                            seen_one <= seen_one | rx;
                            st       <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_end) begin
                            cnt     <= '0;
                            valid   <= 1'b1;
                            ch.data <= is_brk ? '0 : aligned;
                            ch.perr <= !is_brk && par_bad;
                            ch.ferr <= stop_bad;
                            ch.brk  <= is_brk;
                            if (is_brk) begin
                                st <= ST_BRKWAIT;
                            end else if (stop_bad) begin
                                idx      <= '0;
                                shreg    <= '0;
                                seen_one <= 1'b0;
                                st       <= ST_DATA;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_BRKWAIT: begin
                        if (rx) st <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R6
    brk_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && ch.brk) |-> (ch.ferr && !ch.perr && ch.data == '0));

    // R3
    perr_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !cfg.par_en) |-> !ch.perr);

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> ((ch.data & ~word_mask(cfg.wlen)) == '0));

    // R7
    brkwait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BRKWAIT && $past(st) == ST_BRKWAIT) |-> !valid);
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rxb_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       os_tick,
    input  logic [1:0] word_len,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_brk
);
    logic     line_s;
    rx_cfg_t  cfg;
    rx_char_t ch;

    assign cfg = '{wlen: word_len, par_en: par_en, par_odd: par_odd};

    uart_rxb_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s)
    );

    uart_rxb_core #(.OVS(OVS)) core_i (
        .clk   (clk),
        .rst   (rst),
        .rx    (line_s),
        .tick  (os_tick),
        .cfg   (cfg),
        .valid (rx_valid),
        .ch    (ch)
    );

    assign rx_data = ch.data;
    assign rx_perr = ch.perr;
    assign rx_ferr = ch.ferr;
    assign rx_brk  = ch.brk;
endmodule

// File: tb/uart_rx_brk_tb.sv
module uart_rx_brk_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;
    localparam int WD_LIMIT   = 100000;

    typedef struct packed {
        logic [1:0] wl;
        logic       pe;
        logic       po;
        logic [7:0] d;
        logic       bad_par;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b0, 1'b0, 8'hA5, 1'b0},
        '{2'd3, 1'b1, 1'b0, 8'h3C, 1'b0},
        '{2'd3, 1'b1, 1'b1, 8'h3C, 1'b0},
        '{2'd3, 1'b1, 1'b0, 8'h81, 1'b1},
        '{2'd0, 1'b0, 1'b0, 8'hF5, 1'b0},
        '{2'd1, 1'b1, 1'b1, 8'h2A, 1'b0},
        '{2'd2, 1'b1, 1'b0, 8'hFF, 1'b1},
        '{2'd0, 1'b1, 1'b1, 8'h00, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_brk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n_valid = 0;
    logic [10:0] caps    [16];
    int          cap_cyc [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_brk dut_i (
        .clk(clk), .rst(rst), .rxd(rxd), .os_tick(os_tick),
        .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        os_tick <= ~os_tick;
        if (!rst && rx_valid) begin
            caps[n_valid % 16]    <= {rx_data, rx_perr, rx_ferr, rx_brk};
            cap_cyc[n_valid % 16] <= cyc;
            n_valid <= n_valid + 1;
        end
        if (cyc == WD_LIMIT) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic b);
        rxd = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [1:0] wl, input logic pe, input logic po,
                              input logic [7:0] d, input logic bad_par,
                              input logic stop, input bit with_start,
                              output int stop_at);
        logic [7:0] m;
        m = 8'hFF >> (2'd3 - wl);
        word_len = wl; par_en = pe; par_odd = po;
        if (with_start) drive(1'b0);
        for (int i = 0; i < 5 + int'(wl); i++) drive(d[i]);
        if (pe) drive(((^(d & m)) ^ po) ^ bad_par);
        stop_at = cyc;
        drive(stop);
    endtask

    task automatic check_char(input string req, input int idx,
                              input logic [7:0] ed, input logic ep,
                              input logic ef, input logic eb);
        logic [10:0] c;
        c = caps[idx % 16];
        check(c[10:3] == ed, req, "data", c[10:3], ed);
        check(c[2] == ep, req, "perr", c[2], ep);
        check(c[1] == ef, req, "ferr", c[1], ef);
        check(c[0] == eb, req, "brk",  c[0], eb);
    endtask

    initial begin
        int base;
        int sa;
        int sa2;
        logic [7:0] m;
        logic [7:0] ed;
        logic       ep;

        repeat (6) @(negedge clk);
        // R1: outputs quiet during reset
        check({rx_valid, rx_data, rx_perr, rx_ferr, rx_brk} == 12'h0, "R1", "outputs in reset",
              {rx_valid, rx_data, rx_perr, rx_ferr, rx_brk}, 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: still quiet right after release
        check({rx_valid, rx_data, rx_perr, rx_ferr, rx_brk} == 12'h0, "R1", "outputs after release",
              {rx_valid, rx_data, rx_perr, rx_ferr, rx_brk}, 0);
        drive(1'b1); drive(1'b1);

        // R2 R3 R9: table of well-formed frames
        for (int v = 0; v < NV; v++) begin
            base = n_valid;
            send_frame(VECS[v].wl, VECS[v].pe, VECS[v].po, VECS[v].d, VECS[v].bad_par,
                       1'b1, 1'b1, sa);
            drive(1'b1); drive(1'b1);
            m  = 8'hFF >> (2'd3 - VECS[v].wl);
            ed = VECS[v].d & m;
            ep = VECS[v].pe & VECS[v].bad_par;
            check(n_valid == base + 1, "R9", "strobe count per frame", n_valid - base, 1);
            check(cap_cyc[base % 16] >= sa && cap_cyc[base % 16] < sa + BIT_CLKS, "R9",
                  "strobe in stop window", cap_cyc[base % 16] - sa, BIT_CLKS / 2);
            check_char("R2_R3", base, ed, ep, 1'b0, 1'b0);
        end

        // R8: short low pulse is ignored
        base = n_valid;
        rxd = 1'b0;
        repeat (BIT_CLKS / 4) @(negedge clk);
        drive(1'b1); drive(1'b1); drive(1'b1);
        check(n_valid == base, "R8", "glitch produced chars", n_valid - base, 0);
        base = n_valid;
        send_frame(2'd3, 1'b0, 1'b0, 8'h96, 1'b0, 1'b1, 1'b1, sa);
        drive(1'b1); drive(1'b1);
        check(n_valid == base + 1, "R8", "char after glitch", n_valid - base, 1);
        check_char("R8", base, 8'h96, 1'b0, 1'b0, 1'b0);

        // R4 R5: framing error then resync on bad stop bit
        base = n_valid;
        send_frame(2'd3, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 1'b1, sa);
        send_frame(2'd3, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b1, 1'b0, sa2);
        drive(1'b1); drive(1'b1);
        check(n_valid == base + 2, "R5", "chars across resync", n_valid - base, 2);
        check_char("R4", base, 8'h5A, 1'b0, 1'b1, 1'b0);
        check_char("R5", base + 1, 8'hC3, 1'b0, 1'b0, 1'b0);

        // R6 R7: long break with parity enabled, then recovery
        base = n_valid;
        word_len = 2'd3; par_en = 1'b1; par_odd = 1'b0;
        for (int k = 0; k < 30; k++) drive(1'b0);
        check(n_valid == base + 1, "R7", "chars during long break", n_valid - base, 1);
        check_char("R6", base, 8'h00, 1'b0, 1'b1, 1'b1);
        drive(1'b1); drive(1'b1);
        check(n_valid == base + 1, "R7", "chars after line high", n_valid - base, 1);
        base = n_valid;
        send_frame(2'd3, 1'b1, 1'b0, 8'h3F, 1'b0, 1'b1, 1'b1, sa);
        drive(1'b1); drive(1'b1);
        check(n_valid == base + 1, "R7", "char after break", n_valid - base, 1);
        check_char("R7", base, 8'h3F, 1'b0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule